// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between the serial protocol engine of a byte-addressed non-volatile memory and its storage array. When the engine has decoded a write command, it opens a page with a start event that carries the full 11-bit byte address. Each data byte the engine then receives is placed in a 16-byte holding latch, and a per-slot valid mask records which slots were filled. Only the low four address bits advance from byte to byte, and they wrap inside the page. The upper seven bits of the address stay fixed.

The array sees nothing while the bytes arrive. When the engine reports STOP, the block first checks the write-protect input and whether any byte has been received. If the commit goes ahead, the block raises `busy` and waits a programmable number of clocks, which stands in for the erase and program time. It then scans the 16 slots in ascending order and writes every valid slot to the array, one slot per clock. While `busy` is high, the serial engine must not acknowledge, and the block ignores every page event.

Top module: `page_write_buffer`

## Requirements
- R1: A page start loads address bits [10:4] as the page base and bits [3:0] as the slot pointer. Every array write of that transaction carries that base in `arr_addr[10:4]`.
- R2: Each `byte_valid` pulse inside an open page stores `byte_data` at the current slot and then advances the pointer by one, modulo 16.
- R3: When more than 16 bytes arrive before STOP, the pointer wraps and each later byte replaces the earlier content of its slot. Only the last value written to a slot is committed.
- R4: `arr_we` stays low while bytes are being collected. A write happens only while `busy` is high.
- R5: A STOP with at least one received byte and `wp` low raises `busy` on the next clock. `busy` then stays high for CYCLE_CLKS+17 clocks: one hand-off clock, CYCLE_CLKS wait clocks and 16 scan clocks. The writes come out in ascending slot order during the scan. `busy` falls on the clock after slot 15 has been scanned.
- R6: Only slots written since the most recent page start are committed. A new page start, even one that arrives without a STOP, clears the valid mask.
- R7: A STOP that arrives after a page start but before any data byte leaves `busy` low and produces no array write.
- R8: `wp` is sampled in the STOP clock. When it is high, the buffered bytes are discarded, `busy` stays low and no array write occurs.
- R9: While `busy` is high, page starts, data bytes and STOP are ignored. They neither start a further commit nor open a page.
- R10: Data bytes and STOP that arrive while no page is open are ignored.
- R11: After reset, `busy` and `arr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | One-clock pulse that opens a page |
| page_addr | input | 11 | Byte address that comes with `page_start` |
| byte_valid | input | 1 | One-clock strobe for a received data byte |
| byte_data | input | 8 | Data byte that comes with `byte_valid` |
| stop | input | 1 | One-clock pulse for a STOP on the bus |
| wp | input | 1 | Write protect, sampled with `stop` |
| busy | output | 1 | High while a write cycle is in progress |
| arr_we | output | 1 | Array write strobe, one clock per byte |
| arr_addr | output | 11 | Array byte address |
| arr_wdata | output | 8 | Array write data |

## Verification
A wrong slot pointer or base shows at the ports as a wrong address or wrong data in the array writes. That error becomes visible CYCLE_CLKS+1 to CYCLE_CLKS+17 clocks after STOP, when the scan reaches the affected slot. A stale or wrongly cleared valid mask shows as an extra write or a missing write within the same scan window. A fault in the sequencer counter shows as a `busy` interval of the wrong length, or as a write at the wrong moment, and this is visible by the end of the expected busy window. A fault in gating shows as a `busy` pulse or a write after a protected, empty or ignored STOP.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WAIT  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pwb_collect.sv
module pwb_collect #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int BASE_W    = ADDR_W - OFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  blocked,
    input  logic                  page_start,
    input  logic [ADDR_W-1:0]     page_addr,
    input  logic                  byte_valid,
    input  logic [DATA_W-1:0]     byte_data,
    input  logic                  stop,
    input  logic                  wp,
    input  logic [OFS_W-1:0]      rd_slot,
    output logic [BASE_W-1:0]     base,
    output logic [PAGE_BYTES-1:0] mask,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  commit_go
);

    typedef struct packed {
        logic                  active;
        logic [BASE_W-1:0]     base;
        logic [OFS_W-1:0]      ptr;
        logic [PAGE_BYTES-1:0] mask;
        logic                  go;
    } col_t;

    col_t              st_d, st_q;
    logic [DATA_W-1:0] slot_d [PAGE_BYTES];
    logic [DATA_W-1:0] slot_q [PAGE_BYTES];

    always_comb begin
        logic [PAGE_BYTES-1:0] mask_n;
        st_d   = st_q;
        slot_d = slot_q;
        mask_n = st_q.mask;
        st_d.go = 1'b0;
        if (!blocked) begin
            if (page_start) begin
                // a fresh page always clears the valid mask
                st_d.active = 1'b1;
                st_d.base   = page_addr[ADDR_W-1:OFS_W];
                st_d.ptr    = page_addr[OFS_W-1:0];
                st_d.mask   = '0;
            end else if (st_q.active) begin
                if (byte_valid) begin
                    slot_d[st_q.ptr] = byte_data;
                    mask_n[st_q.ptr] = 1'b1;
                    st_d.ptr         = st_q.ptr + OFS_W'(1);
                end
                st_d.mask = mask_n;
                if (stop) begin
                    st_d.active = 1'b0;
                    st_d.go     = (mask_n != '0) && !wp;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) slot_q[i] <= '0;
        end else begin
            st_q   <= st_d;
            slot_q <= slot_d;
        end
    end

    assign base      = st_q.base;
    assign mask      = st_q.mask;
    assign commit_go = st_q.go;
    assign rd_data   = slot_q[rd_slot];

endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int CYCLE_CLKS = 64,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int CYC_W     = $clog2(CYCLE_CLKS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [PAGE_BYTES-1:0] mask,
    output logic                  active,
    output logic [OFS_W-1:0]      slot,
    output logic                  we
);

    localparam logic [CYC_W-1:0] CNT_LAST  = CYC_W'(CYCLE_CLKS - 1);
    localparam logic [OFS_W-1:0] SLOT_LAST = OFS_W'(PAGE_BYTES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CYC_W-1:0] cnt;
        logic [OFS_W-1:0] slot;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.state)
            SQ_IDLE: begin
                if (go) begin
                    sq_d.state = SQ_WAIT;
                    sq_d.cnt   = '0;
                end
            end
            SQ_WAIT: begin
                if (sq_q.cnt == CNT_LAST) begin
                    sq_d.state = SQ_WRITE;
                    sq_d.slot  = '0;
                end else begin
                    sq_d.cnt = sq_q.cnt + CYC_W'(1);
                end
            end
            SQ_WRITE: begin
                if (sq_q.slot == SLOT_LAST) sq_d.state = SQ_IDLE;
                else                        sq_d.slot  = sq_q.slot + OFS_W'(1);
            end
            default: sq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{state: SQ_IDLE, cnt: '0, slot: '0};
        else        sq_q <= sq_d;
    end

    assign active = (sq_q.state != SQ_IDLE);
    assign slot   = sq_q.slot;
    assign we     = (sq_q.state == SQ_WRITE) && mask[sq_q.slot];

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int CYCLE_CLKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_start,
    input  logic [ADDR_W-1:0] page_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop,
    input  logic              wp,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);

    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFS_W;

    logic [BASE_W-1:0]     page_base;
    logic [PAGE_BYTES-1:0] valid_mask;
    logic [DATA_W-1:0]     slot_data;
    logic [OFS_W-1:0]      scan_slot;
    logic                  commit_go;
    logic                  seq_active;

    pwb_collect #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_collect (
        .clk(clk), .rst_n(rst_n), .blocked(busy),
        .page_start(page_start), .page_addr(page_addr),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .stop(stop), .wp(wp), .rd_slot(scan_slot),
        .base(page_base), .mask(valid_mask), .rd_data(slot_data),
        .commit_go(commit_go)
    );

    pwb_sequencer #(
        .PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .go(commit_go), .mask(valid_mask),
        .active(seq_active), .slot(scan_slot), .we(arr_we)
    );

    assign busy      = commit_go | seq_active;
    assign arr_addr  = {page_base, scan_slot};
    assign arr_wdata = slot_data;

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 16,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop,
    input logic              wp,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);

    assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop));

    assert_scan_ends_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(arr_addr[OFS_W-1:0]) == OFS_W'(PAGE_BYTES - 1)));

    assert_base_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:OFS_W]));

    assert_wp_no_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && wp && !busy) |=> !busy);

endmodule

bind page_write_buffer pwb_checker #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
) u_pwb_checker (
    .clk(clk), .rst_n(rst_n), .stop(stop), .wp(wp),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/tb_page_write_buffer.sv
module tb_page_write_buffer;

    localparam int CYC = 40;
    localparam int BUSY_LEN = CYC + 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_start = 1'b0;
    logic [10:0] page_addr = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop = 1'b0;
    logic        wp = 1'b0;
    logic        busy, arr_we;
    logic [10:0] arr_addr;
    logic [7:0]  arr_wdata;

    page_write_buffer #(.CYCLE_CLKS(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_addr(page_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop), .wp(wp),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0, busy_cnt = 0, writes_seen = 0;
    bit done = 0;
    string cur_tag = "R1";

    logic [10:0] exp_addr[$];
    logic [7:0]  exp_data[$];

    // reference model of the open page
    logic [7:0]  m_pg [16];
    logic [15:0] m_mask;
    logic [6:0]  m_base;
    logic [3:0]  m_ptr;
    bit          m_open = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop scoreboard on every array write
    always @(negedge clk) begin
        if (rst_n && busy) busy_cnt++;
        if (rst_n && arr_we) begin
            writes_seen++;
            if (exp_addr.size() == 0) begin
                check(0, {cur_tag, " unexpected write"}, int'(arr_addr), 0);
            end else begin
                logic [10:0] ea;
                logic [7:0]  ed;
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                check(arr_addr == ea, {cur_tag, " addr"}, int'(arr_addr), int'(ea));
                check(arr_wdata == ed, {cur_tag, " data"}, int'(arr_wdata), int'(ed));
            end
        end
    end

    task automatic tx_start(input logic [10:0] a, input bit mdl);
        page_start = 1'b1; page_addr = a;
        @(negedge clk);
        page_start = 1'b0;
        if (mdl) begin
            m_open = 1; m_base = a[10:4]; m_ptr = a[3:0]; m_mask = '0;
        end
    endtask

    task automatic tx_byte(input logic [7:0] d, input bit mdl);
        byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
        if (mdl && m_open) begin
            m_pg[m_ptr] = d; m_mask[m_ptr] = 1'b1; m_ptr = m_ptr + 4'd1;
        end
    endtask

    task automatic tx_stop(input bit prot, input bit mdl);
        stop = 1'b1; wp = prot;
        @(negedge clk);
        stop = 1'b0; wp = 1'b0;
        if (mdl && m_open) begin
            m_open = 0;
            if (!prot)
                for (int s = 0; s < 16; s++)
                    if (m_mask[s]) begin
                        exp_addr.push_back({m_base, 4'(s)});
                        exp_data.push_back(m_pg[s]);
                    end
        end
    endtask

    task automatic finish_tx(input string req, input int snap, input int exp_len);
        repeat (CYC + 30) @(negedge clk);
        check(busy_cnt - snap == exp_len, {req, " busy length"}, busy_cnt - snap, exp_len);
        check(exp_addr.size() == 0, {req, " missing writes"}, exp_addr.size(), 0);
    endtask

    initial begin
        int snap, w0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R11 busy in reset", busy, 0);
        check(arr_we == 1'b0, "R11 we in reset", arr_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R11 busy after reset", busy, 0);

        // R1 R5: single-byte write
        cur_tag = "R1"; snap = busy_cnt;
        tx_start(11'h123, 1); tx_byte(8'hA5, 1);
        check(busy == 1'b0, "R5 busy before stop", busy, 0);
        tx_stop(0, 1);
        check(busy == 1'b1, "R5 busy after stop", busy, 1);
        finish_tx("R5", snap, BUSY_LEN);

        // R2 R4: full page
        cur_tag = "R2"; snap = busy_cnt;
        tx_start(11'h450, 1);
        for (int i = 0; i < 16; i++) tx_byte(8'(i * 3 + 1), 1);
        w0 = writes_seen;
        repeat (5) @(negedge clk);
        check(writes_seen == w0 && busy == 1'b0, "R4 no write before stop", writes_seen - w0, 0);
        tx_stop(0, 1);
        finish_tx("R2", snap, BUSY_LEN);

        // R3: 20 bytes starting at offset 14 wrap and overwrite
        cur_tag = "R3"; snap = busy_cnt;
        tx_start(11'h2AE, 1);
        for (int i = 0; i < 20; i++) tx_byte(8'(8'hC0 + i), 1);
        tx_stop(0, 1);
        finish_tx("R3", snap, BUSY_LEN);

        // R6: mask cleared by a restart without stop
        cur_tag = "R6"; snap = busy_cnt;
        tx_start(11'h100, 1); tx_byte(8'h11, 1); tx_byte(8'h22, 1);
        tx_start(11'h108, 1); tx_byte(8'h33, 1);
        tx_stop(0, 1);
        finish_tx("R6", snap, BUSY_LEN);
        // R6: shorter transaction on a page just committed
        snap = busy_cnt;
        tx_start(11'h105, 1); tx_byte(8'h44, 1);
        tx_stop(0, 1);
        finish_tx("R6", snap, BUSY_LEN);

        // R7: stop with no data
        cur_tag = "R7"; snap = busy_cnt;
        tx_start(11'h200, 1);
        tx_stop(0, 1);
        finish_tx("R7", snap, 0);

        // R8: write protect at stop discards
        cur_tag = "R8"; snap = busy_cnt;
        tx_start(11'h3F0, 1); tx_byte(8'h5A, 1); tx_byte(8'h6B, 1);
        tx_stop(1, 1);
        finish_tx("R8", snap, 0);

        // R9: activity during busy ignored
        cur_tag = "R9"; snap = busy_cnt;
        tx_start(11'h600, 1); tx_byte(8'h77, 1);
        tx_stop(0, 1);
        tx_start(11'h010, 0); tx_byte(8'h99, 0); tx_byte(8'h98, 0);
        tx_stop(0, 0);
        finish_tx("R9", snap, BUSY_LEN);
        snap = busy_cnt;
        tx_byte(8'h97, 0);
        tx_stop(0, 0);
        finish_tx("R9", snap, 0);

        // R10: bytes and stop with no page open
        cur_tag = "R10"; snap = busy_cnt;
        tx_byte(8'h12, 0); tx_byte(8'h34, 0);
        tx_stop(0, 0);
        finish_tx("R10", snap, 0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule